// File: doc/BRIEF.md
# Descriptor-Ring Pause Request Generator

This block decides when the receive side of an Ethernet port should ask its link partner to stop sending. It watches eight receive descriptor rings. For each ring, software programs a ring length and a minimum count of free descriptors. Software also moves a free pointer forward as it returns descriptors. Hardware advances a consume index each time the receive engine takes a descriptor. From the free pointer and the consume index, the block keeps a live free-descriptor count for every ring.

A small state machine turns those counts into a registered pause request. Its states are:
- `ST_IDLE`: automatic control is off and no manual pause is set.
- `ST_WATCH`: automatic control is on and every active ring is at or above its threshold.
- `ST_HOLD`: automatic control is on and at least one active ring is short of free descriptors.
- `ST_FORCED`: software has set the manual pause bit.

From any state, the next state is chosen in this priority order:
1. If `manual_pause` is set, go to `ST_FORCED`.
2. Otherwise, if `lfc_en` is clear, go to `ST_IDLE`.
3. Otherwise, if any active ring is short, go to `ST_HOLD`.
4. Otherwise, go to `ST_WATCH`.

The pause request is high in `ST_HOLD` and `ST_FORCED`.

While automatic control is on and a frame is being received, the ring parameters must not change. A parameter write made at such a time is dropped and sets a sticky error flag.

Top module: `pause_req_gen`

## Requirements
- R1: While `lfc_en` is 0 and `manual_pause` is 0, `pause_req` is 0 one clock later, whatever the ring counts are.
- R2: A write with `wr_addr[3]`=0 programs ring `wr_addr[2:0]`. It sets the length from `wr_data[7:0]` and the threshold from `wr_data[15:8]`, and it clears that ring's free pointer and consume index, so the ring's count becomes 0.
- R3: A write with `wr_addr[3]`=1 loads the free pointer of ring `wr_addr[2:0]` from `wr_data[7:0]`. The write is dropped if that value is not below the ring length.
- R4: `free_cnt[8r+7:8r]` always equals (free pointer − consume index) modulo the length of ring r. It updates in the clock after any change to either index.
- R5: A `consume[r]` pulse advances ring r's consume index by one, wrapping from length−1 to 0. The pulse has no effect on a ring whose length is 0.
- R6: When `lfc_en` is 1 and an active ring's count is below its threshold, `pause_req` is 1 one clock later.
- R7: When `lfc_en` is 1, `manual_pause` is 0, and every active ring's count is greater than or equal to its threshold, `pause_req` is 0 one clock later. A count equal to the threshold does not pause.
- R8: Rings whose `active_mask` bit is 0, and rings of length 0, never cause a pause.
- R9: A parameter write while `lfc_en` and `rx_busy` are both 1 leaves the ring unchanged and sets `param_err`. `param_err` stays 1 until reset, including across later legal writes.
- R10: `manual_pause` set to 1 makes `pause_req` 1 one clock later, even with `lfc_en` 0.
- R11: After reset, `pause_req` is 0, `param_err` is 0, and every ring has length 0, threshold 0 and count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Bit 3 selects the free pointer (1) or the parameters (0); bits 2:0 select the ring |
| wr_data | input | 16 | Write data: length [7:0] and threshold [15:8], or free pointer [7:0] |
| consume | input | 8 | One pulse per descriptor taken, one bit per ring |
| active_mask | input | 8 | Rings that take part in the pause decision |
| lfc_en | input | 1 | Automatic flow-control enable |
| rx_busy | input | 1 | Reception in progress |
| manual_pause | input | 1 | Software-forced pause |
| pause_req | output | 1 | Registered pause request |
| free_cnt | output | 64 | Free-descriptor count per ring, 8 bits each, ring 0 in the low byte |
| param_err | output | 1 | Sticky flag for a dropped parameter write |

## Verification
The hardest case to reach from the ports is a wrap of the consume index while a free pointer sits below it, because the count then comes from the modular branch. The stimulus reaches this case in two ways. It rewrites a free pointer to a value smaller than the consume index. It also pulses `consume` until a short ring wraps back to index 0. The bench also drives a parameter write in the same cycle as `rx_busy` with automatic control on. It then reads the unchanged count back through `free_cnt` to show that the dropped write had no effect.

// File: rtl/pause_pkg.sv
package pause_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WATCH  = 2'd1,
        ST_HOLD   = 2'd2,
        ST_FORCED = 2'd3
    } pause_state_e;
endpackage

// File: rtl/ring_tracker.sv
module ring_tracker #(
    parameter int LENW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prm_we,
    input  logic            fp_we,
    input  logic [LENW-1:0] new_len,
    input  logic [LENW-1:0] new_thr,
    input  logic [LENW-1:0] new_fp,
    input  logic            consume,
    output logic [LENW-1:0] free_cnt,
    output logic            below
);
    logic [LENW-1:0] len_q, thr_q, fp_q, idx_q;
    logic [LENW:0]   idx_inc;

    assign idx_inc = {1'b0, idx_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            thr_q <= '0;
            fp_q  <= '0;
            idx_q <= '0;
        end else if (prm_we) begin
            len_q <= new_len;
            thr_q <= new_thr;
            fp_q  <= '0;
            idx_q <= '0;
        end else begin
            if (fp_we && (new_fp < len_q))
                fp_q <= new_fp;
            if (consume && (len_q != '0))
                idx_q <= (idx_inc == {1'b0, len_q}) ? '0 : idx_inc[LENW-1:0];
        end
    end

    always_comb begin
        if (fp_q >= idx_q)
            free_cnt = fp_q - idx_q;
        else
            free_cnt = fp_q + len_q - idx_q;
    end

    assign below = (len_q != '0) && (free_cnt < thr_q);
endmodule

// File: rtl/pause_fsm.sv
module pause_fsm
    import pause_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lfc_en,
    input  logic         manual_pause,
    input  logic         any_low,
    output pause_state_e state,
    output logic         pause_req
);
    pause_state_e state_q, state_d;

    always_comb begin
        if (manual_pause)
            state_d = ST_FORCED;
        else if (!lfc_en)
            state_d = ST_IDLE;
        else if (any_low)
            state_d = ST_HOLD;
        else
            state_d = ST_WATCH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   pause_req = 1'b0;
            ST_WATCH:  pause_req = 1'b0;
            ST_HOLD:   pause_req = 1'b1;
            ST_FORCED: pause_req = 1'b1;
            default:   pause_req = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/pause_req_gen.sv
module pause_req_gen
    import pause_pkg::*;
#(
    parameter int NRINGS = 8,
    parameter int LENW   = 8,
    localparam int RSELW = $clog2(NRINGS),
    localparam int ADDRW = RSELW + 1,
    localparam int DATAW = 2 * LENW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDRW-1:0]       wr_addr,
    input  logic [DATAW-1:0]       wr_data,
    input  logic [NRINGS-1:0]      consume,
    input  logic [NRINGS-1:0]      active_mask,
    input  logic                   lfc_en,
    input  logic                   rx_busy,
    input  logic                   manual_pause,
    output logic                   pause_req,
    output logic [NRINGS*LENW-1:0] free_cnt,
    output logic                   param_err
);
    logic              wr_is_fp;
    logic [RSELW-1:0]  wr_ring;
    logic              prm_locked;
    logic              prm_illegal;
    logic [NRINGS-1:0] below_vec;
    logic [NRINGS-1:0] low_vec;
    logic              err_q;
    pause_state_e      state;

    assign wr_is_fp    = wr_addr[RSELW];
    assign wr_ring     = wr_addr[RSELW-1:0];
    assign prm_locked  = lfc_en && rx_busy;
    assign prm_illegal = wr_en && !wr_is_fp && prm_locked;

    for (genvar r = 0; r < NRINGS; r++) begin : g_ring
        logic sel;
        assign sel = wr_en && (wr_ring == RSELW'(r));
        ring_tracker #(.LENW(LENW)) i_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .prm_we   (sel && !wr_is_fp && !prm_locked),
            .fp_we    (sel && wr_is_fp),
            .new_len  (wr_data[LENW-1:0]),
            .new_thr  (wr_data[DATAW-1:LENW]),
            .new_fp   (wr_data[LENW-1:0]),
            .consume  (consume[r]),
            .free_cnt (free_cnt[r*LENW +: LENW]),
            .below    (below_vec[r])
        );
    end

    assign low_vec = below_vec & active_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (prm_illegal)
            err_q <= 1'b1;
    end
    assign param_err = err_q;

    pause_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .lfc_en       (lfc_en),
        .manual_pause (manual_pause),
        .any_low      (|low_vec),
        .state        (state),
        .pause_req    (pause_req)
    );
endmodule

// File: rtl/pause_req_gen_chk.sv
module pause_req_gen_chk #(
    parameter int NRINGS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic              lfc_en,
    input logic              rx_busy,
    input logic              manual_pause,
    input logic [NRINGS-1:0] low_vec,
    input logic              pause_req,
    input logic              param_err
);
    a_r1_off_no_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (!lfc_en && !manual_pause) |=> !pause_req);

    a_r6_low_pauses: assert property (@(posedge clk) disable iff (!rst_n)
        (lfc_en && (low_vec != '0)) |=> pause_req);

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (lfc_en && !manual_pause && (low_vec == '0)) |=> !pause_req);

    a_r10_manual: assert property (@(posedge clk) disable iff (!rst_n)
        manual_pause |=> pause_req);

    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[3] && lfc_en && rx_busy) |=> param_err);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        param_err |=> param_err);
endmodule

bind pause_req_gen pause_req_gen_chk #(.NRINGS(NRINGS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .lfc_en       (lfc_en),
    .rx_busy      (rx_busy),
    .manual_pause (manual_pause),
    .low_vec      (low_vec),
    .pause_req    (pause_req),
    .param_err    (param_err)
);

// File: tb/test_pause_req_gen.sv
module test_pause_req_gen;
    localparam int PERIOD = 10;
    localparam int N_VEC  = 20;

    typedef struct packed {
        logic [1:0]  op;     // 0 param, 1 free ptr, 2 consume, 3 none
        logic [2:0]  ring;
        logic [15:0] data;
        logic        lfc;
        logic        man;
        logic [7:0]  mask;
        logic [7:0]  cnt;
        logic        pause;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{2'd0, 3'd0, 16'h0308, 1'b0, 1'b0, 8'h01, 8'd0, 1'b0}, // R2
        '{2'd1, 3'd0, 16'h0005, 1'b0, 1'b0, 8'h01, 8'd5, 1'b0}, // R3 R1
        '{2'd3, 3'd0, 16'h0000, 1'b1, 1'b0, 8'h01, 8'd5, 1'b0}, // R7
        '{2'd2, 3'd0, 16'h0000, 1'b1, 1'b0, 8'h01, 8'd4, 1'b0}, // R5
        '{2'd2, 3'd0, 16'h0000, 1'b1, 1'b0, 8'h01, 8'd3, 1'b0}, // R7 equal
        '{2'd2, 3'd0, 16'h0000, 1'b1, 1'b0, 8'h01, 8'd2, 1'b1}, // R6
        '{2'd1, 3'd0, 16'h0007, 1'b1, 1'b0, 8'h01, 8'd4, 1'b0}, // R4
        '{2'd1, 3'd0, 16'h0001, 1'b1, 1'b0, 8'h01, 8'd6, 1'b0}, // R4 modular
        '{2'd0, 3'd1, 16'h0204, 1'b1, 1'b0, 8'h01, 8'd0, 1'b0}, // R8 inactive
        '{2'd3, 3'd1, 16'h0000, 1'b1, 1'b0, 8'h03, 8'd0, 1'b1}, // R6
        '{2'd1, 3'd1, 16'h0003, 1'b1, 1'b0, 8'h03, 8'd3, 1'b0}, // R3
        '{2'd1, 3'd1, 16'h0004, 1'b1, 1'b0, 8'h03, 8'd3, 1'b0}, // R3 dropped
        '{2'd2, 3'd1, 16'h0000, 1'b1, 1'b0, 8'h03, 8'd2, 1'b0}, // R7
        '{2'd2, 3'd1, 16'h0000, 1'b1, 1'b0, 8'h03, 8'd1, 1'b1}, // R6
        '{2'd3, 3'd1, 16'h0000, 1'b0, 1'b0, 8'h03, 8'd1, 1'b0}, // R1
        '{2'd3, 3'd1, 16'h0000, 1'b0, 1'b1, 8'h03, 8'd1, 1'b1}, // R10
        '{2'd3, 3'd1, 16'h0000, 1'b0, 1'b0, 8'h03, 8'd1, 1'b0}, // R10 off
        '{2'd2, 3'd1, 16'h0000, 1'b0, 1'b0, 8'h03, 8'd0, 1'b0}, // R5
        '{2'd2, 3'd1, 16'h0000, 1'b0, 1'b0, 8'h03, 8'd3, 1'b0}, // R5 wrap
        '{2'd3, 3'd0, 16'h0000, 1'b1, 1'b0, 8'h03, 8'd6, 1'b0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  consume = '0;
    logic [7:0]  active_mask = '0;
    logic        lfc_en = 1'b0;
    logic        rx_busy = 1'b0;
    logic        manual_pause = 1'b0;
    logic        pause_req;
    logic [63:0] free_cnt;
    logic        param_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pause_req_gen i_pause_req_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .consume      (consume),
        .active_mask  (active_mask),
        .lfc_en       (lfc_en),
        .rx_busy      (rx_busy),
        .manual_pause (manual_pause),
        .pause_req    (pause_req),
        .free_cnt     (free_cnt),
        .param_err    (param_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one operation at a falling edge, then settle two edges
    task automatic do_op(input logic [1:0] op, input logic [2:0] ring, input logic [15:0] data);
        @(negedge clk);
        wr_en   = (op == 2'd0) || (op == 2'd1);
        wr_addr = {(op == 2'd1), ring};
        wr_data = data;
        consume = (op == 2'd2) ? (8'h01 << ring) : 8'h00;
        @(negedge clk);
        wr_en   = 1'b0;
        consume = '0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        check("R11 pause", {63'd0, pause_req}, 64'd0);
        check("R11 err", {63'd0, param_err}, 64'd0);
        check("R11 counts", free_cnt, 64'd0);

        for (int i = 0; i < N_VEC; i++) begin
            lfc_en       = VECS[i].lfc;
            manual_pause = VECS[i].man;
            active_mask  = VECS[i].mask;
            do_op(VECS[i].op, VECS[i].ring, VECS[i].data);
            check($sformatf("R4 vec%0d count", i),
                  {56'd0, free_cnt[VECS[i].ring*8 +: 8]}, {56'd0, VECS[i].cnt});
            check($sformatf("R6 R7 vec%0d pause", i),
                  {63'd0, pause_req}, {63'd0, VECS[i].pause});
        end

        // R9 parameter write during reception with control on is dropped
        rx_busy = 1'b1;
        do_op(2'd0, 3'd0, 16'h0102);
        check("R9 ring0 unchanged", {56'd0, free_cnt[7:0]}, 64'd6);
        check("R9 err set", {63'd0, param_err}, 64'd1);
        rx_busy = 1'b0;
        do_op(2'd0, 3'd2, 16'h0010);
        check("R2 legal write ring2", {56'd0, free_cnt[23:16]}, 64'd0);
        check("R9 err sticky", {63'd0, param_err}, 64'd1);
        // R9 a free-pointer write while busy is still accepted
        rx_busy = 1'b1;
        do_op(2'd1, 3'd2, 16'h0009);
        check("R3 fp while busy", {56'd0, free_cnt[23:16]}, 64'd9);
        rx_busy = 1'b0;

        // R8 zero-length rings never pause; R5 consume ignored at length 0
        do_reset();
        check("R11 err cleared", {63'd0, param_err}, 64'd0);
        lfc_en = 1'b1;
        active_mask = 8'hFF;
        @(negedge clk);
        consume = 8'hFF;
        @(negedge clk);
        consume = 8'h00;
        @(negedge clk);
        check("R8 zero length no pause", {63'd0, pause_req}, 64'd0);
        check("R5 zero length count", free_cnt, 64'd0);

        // highest ring, threshold 1 on length 2
        do_op(2'd0, 3'd7, 16'h0102);
        check("R6 ring7 pause", {63'd0, pause_req}, 64'd1);
        do_op(2'd1, 3'd7, 16'h0001);
        check("R4 ring7 count", {56'd0, free_cnt[63:56]}, 64'd1);
        check("R7 ring7 release", {63'd0, pause_req}, 64'd0);
        // R8 masking a short ring releases pause
        do_op(2'd2, 3'd7, 16'h0000);
        check("R6 ring7 short again", {63'd0, pause_req}, 64'd1);
        active_mask = 8'h7F;
        @(negedge clk);
        check("R8 masked ring", {63'd0, pause_req}, 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule